// File: doc/BRIEF.md
# PHY Link and Duplex Resolver

This block polls an Ethernet PHY over an external MDIO management master and folds the result into the MAC's operating-mode word. A single-cycle start pulse launches a pass: the block reads the PHY's basic status register and its link-partner ability register, then re-reads status when the link bit reads low, because that bit latches low until read. It then decides whether the PHY is absent, whether the link is down, or what the mode word should become.

The ability bits that both ends share are the partner word masked by the local advertisement. From them the block sets or clears a transmit-threshold bit (100 Mb/s shared or not) and a full-duplex bit. A duplex-lock input forces the full-duplex result. When the resolved word differs from the supplied one, the block presents the new word and pulses `changed`, which lets the surrounding logic restart the transmit and receive paths.

The MDIO master is reached through a small request/response port. `mdio_rd_req` is a one-cycle pulse that comes with a PHY address and a register number, and the master later answers with a one-cycle `mdio_rd_done` together with the data.

Top module: `link_duplex_resolver`

## Requirements
- R1: After reset, `busy`, `done`, `changed` and `mdio_rd_req` are 0, `result` is 2'b00 and `mode_out` is all zeros.
- R2: A pass issues its reads to the PHY address captured at start. It reads register 1 (status) and then register 5 (partner ability). Each read is a single `mdio_rd_req` pulse, and the next request is issued only after the previous `mdio_rd_done`.
- R3: If the first status read returns 0xFFFF, the pass makes no third read and ends with `result` = 2'b10 (code -2). `mode_out` then equals the captured mode word and `changed` stays 0.
- R4: If status bit 2 (link) reads 0 in the first status read, a third read of register 1 is issued. If bit 2 is 0 again, the pass ends with `result` = 2'b11 (code -1), `mode_out` equals the captured mode word and `changed` stays 0.
- R5: If that third read returns bit 2 = 1, resolution proceeds exactly as for a link that was up on the first read.
- R6: Let N = partner & advertisement. Mode bit TXTHR_POS (default 22) is cleared when any of N[9:7] is 1 and set otherwise.
- R7: Mode bit FDX_POS (default 9) is set when the duplex-lock input is 1, when N[8] is 1, or when N[6] is 1 while N[7] is 0. Otherwise it is cleared. All other mode bits are copied unchanged.
- R8: When the resolved word differs from the captured word, `mode_out` takes the resolved word, `changed` pulses with `done` and `result` = 2'b01. Otherwise `result` = 2'b00 and `changed` stays 0. `mode_out` changes only in a cycle where `done` is 1.
- R9: `done` is a one-cycle pulse that is seen in the second cycle after the cycle in which the last read's `mdio_rd_done` was presented. `busy` is 1 from the cycle after start until that pass's final cycle, and it is 0 whenever `done` is 1.
- R10: A start pulse that arrives while `busy` is 1 is ignored. It issues no extra read and does not change the captured PHY address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a resolution pass |
| phy_addr | input | 5 | PHY address for this pass |
| local_adv | input | 16 | Local advertisement word |
| duplex_lock | input | 1 | Forces full duplex when 1 |
| mode_in | input | 32 | Current MAC mode word |
| mdio_rd_req | output | 1 | One-cycle read request to the MDIO master |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_rd_done | input | 1 | Read data valid from the MDIO master |
| mdio_rd_data | input | 16 | Read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished (one cycle) |
| result | output | 2 | Code: 10 missing, 11 no link, 00 unchanged, 01 changed |
| mode_out | output | 32 | Resolved mode word |
| changed | output | 1 | Restart request, pulses with done when the word changed |

## Verification
The bench builds the block with its default parameters: a 32-bit mode word, the threshold bit at 22 and the duplex bit at 9. It uses mode words in which those bits start both set and clear, so every transition direction of both bits is reachable, along with the no-change case. The MDIO responder answers after a different latency in each pass. This checks the two-cycle distance from the last response to `done` independently of how long the master takes, and gives a window in which an extra start pulse can arrive mid-pass.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int unsigned PHY_AW = 5;
  localparam int unsigned MREG_W = 5;
  localparam int unsigned MDAT_W = 16;

  localparam logic [MREG_W-1:0] REG_STATUS  = 5'd1;
  localparam logic [MREG_W-1:0] REG_PARTNER = 5'd5;

  localparam int unsigned LINK_BIT   = 2;
  localparam int unsigned AB_10FD    = 6;
  localparam int unsigned AB_100HD   = 7;
  localparam int unsigned AB_100FD   = 8;
  localparam int unsigned AB_100T4   = 9;

  typedef enum logic [1:0] {
    RES_UNCHANGED = 2'b00,
    RES_CHANGED   = 2'b01,
    RES_MISSING   = 2'b10,
    RES_NOLINK    = 2'b11
  } res_code_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STAT   = 3'd1,
    ST_PART   = 3'd2,
    ST_RECHK  = 3'd3,
    ST_EVAL   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/lnk_resolve.sv
module lnk_resolve
  import lnk_pkg::*;
#(
  parameter int unsigned MODE_W    = 32,
  parameter int unsigned TXTHR_POS = 22,
  parameter int unsigned FDX_POS   = 9
) (
  input  logic [MDAT_W-1:0] partner,
  input  logic [MDAT_W-1:0] adv,
  input  logic              lock,
  input  logic [MODE_W-1:0] mode_cur,
  output logic [MODE_W-1:0] mode_new,
  output logic              differs
);
  logic [MDAT_W-1:0] shared_ab;
  logic              fast_any;
  logic              full_dx;

  always_comb begin
    shared_ab = partner & adv;
    fast_any  = |shared_ab[AB_100T4:AB_100HD];
    full_dx   = lock | shared_ab[AB_100FD] |
                (shared_ab[AB_10FD] & ~shared_ab[AB_100HD]);
    mode_new  = mode_cur;
    mode_new[TXTHR_POS] = ~fast_any;
    mode_new[FDX_POS]   = full_dx;
    differs   = (mode_new != mode_cur);
  end
endmodule

// File: rtl/lnk_seq.sv
module lnk_seq
  import lnk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_done,
  input  logic [MDAT_W-1:0] rd_data,
  output logic              rd_req,
  output logic [MREG_W-1:0] rd_reg,
  output logic              cap_en,
  output logic              part_en,
  output logic              fin,
  output logic              missing,
  output logic              link_up,
  output logic              busy
);
  seq_state_e        st_q, st_d;
  logic              req_q, req_d;
  logic [MREG_W-1:0] reg_q, reg_d;
  logic              stat_en;
  logic              miss_en;
  logic [MDAT_W-1:0] stat_q;
  logic              miss_q;

  always_comb begin
    st_d    = st_q;
    req_d   = 1'b0;
    reg_d   = reg_q;
    cap_en  = 1'b0;
    stat_en = 1'b0;
    miss_en = 1'b0;
    part_en = 1'b0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        cap_en = 1'b1;
        req_d  = 1'b1;
        reg_d  = REG_STATUS;
        st_d   = ST_STAT;
      end
      ST_STAT: if (rd_done) begin
        stat_en = 1'b1;
        miss_en = 1'b1;
        req_d   = 1'b1;
        reg_d   = REG_PARTNER;
        st_d    = ST_PART;
      end
      ST_PART: if (rd_done) begin
        part_en = 1'b1;
        if (!miss_q && !stat_q[LINK_BIT]) begin
          req_d = 1'b1;
          reg_d = REG_STATUS;
          st_d  = ST_RECHK;
        end else begin
          st_d  = ST_EVAL;
        end
      end
      ST_RECHK: if (rd_done) begin
        stat_en = 1'b1;
        st_d    = ST_EVAL;
      end
      ST_EVAL: begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
      reg_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      reg_q <= reg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= 1'b0;
    end else if (miss_en) begin
      miss_q <= (rd_data == {MDAT_W{1'b1}});
    end
  end

  assign rd_req  = req_q;
  assign rd_reg  = reg_q;
  assign missing = miss_q;
  assign link_up = stat_q[LINK_BIT];
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/link_duplex_resolver.sv
module link_duplex_resolver
  import lnk_pkg::*;
#(
  parameter int unsigned MODE_W    = 32,
  parameter int unsigned TXTHR_POS = 22,
  parameter int unsigned FDX_POS   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        phy_addr,
  input  logic [15:0]       local_adv,
  input  logic              duplex_lock,
  input  logic [MODE_W-1:0] mode_in,
  output logic              mdio_rd_req,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  input  logic              mdio_rd_done,
  input  logic [15:0]       mdio_rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic [MODE_W-1:0] mode_out,
  output logic              changed
);
  logic              cap_en, part_en, fin, missing, link_up;
  logic [PHY_AW-1:0] phy_q;
  logic [MDAT_W-1:0] adv_q, part_q;
  logic              lock_q;
  logic [MODE_W-1:0] mode_q, mode_res;
  logic              differs;
  res_code_e         code_d;
  logic [MODE_W-1:0] out_d;
  logic              done_q, chg_q;
  logic [1:0]        res_q;
  logic [MODE_W-1:0] out_q;

  lnk_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_done (mdio_rd_done),
    .rd_data (mdio_rd_data),
    .rd_req  (mdio_rd_req),
    .rd_reg  (mdio_reg),
    .cap_en  (cap_en),
    .part_en (part_en),
    .fin     (fin),
    .missing (missing),
    .link_up (link_up),
    .busy    (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      adv_q  <= '0;
      lock_q <= 1'b0;
      mode_q <= '0;
    end else if (cap_en) begin
      phy_q  <= phy_addr;
      adv_q  <= local_adv;
      lock_q <= duplex_lock;
      mode_q <= mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
    end else if (part_en) begin
      part_q <= mdio_rd_data;
    end
  end

  lnk_resolve #(
    .MODE_W    (MODE_W),
    .TXTHR_POS (TXTHR_POS),
    .FDX_POS   (FDX_POS)
  ) u_res (
    .partner  (part_q),
    .adv      (adv_q),
    .lock     (lock_q),
    .mode_cur (mode_q),
    .mode_new (mode_res),
    .differs  (differs)
  );

  always_comb begin
    if (missing) begin
      code_d = RES_MISSING;
      out_d  = mode_q;
    end else if (!link_up) begin
      code_d = RES_NOLINK;
      out_d  = mode_q;
    end else if (differs) begin
      code_d = RES_CHANGED;
      out_d  = mode_res;
    end else begin
      code_d = RES_UNCHANGED;
      out_d  = mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      done_q <= fin;
      chg_q  <= fin && (code_d == RES_CHANGED);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= 2'b00;
      out_q <= '0;
    end else if (fin) begin
      res_q <= code_d;
      out_q <= out_d;
    end
  end

  assign mdio_phy = phy_q;
  assign done     = done_q;
  assign changed  = chg_q;
  assign result   = res_q;
  assign mode_out = out_q;
endmodule

// File: rtl/lnk_resolver_chk.sv
module lnk_resolver_chk #(
  parameter int unsigned MODE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_rd_req,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic [MODE_W-1:0] mode_out,
  input logic              changed
);
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_rd_req |-> busy); // R2

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_rd_req |=> !mdio_rd_req); // R2

  AST_MISSING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b10) |-> !changed); // R3

  AST_NOLINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b11) |-> !changed); // R4

  AST_CHANGED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    changed |-> (done && result == 2'b01)); // R8

  AST_MODE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mode_out)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
endmodule

bind link_duplex_resolver lnk_resolver_chk #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mdio_rd_req (mdio_rd_req),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .mode_out    (mode_out),
  .changed     (changed)
);

// File: tb/tb_link_duplex_resolver.sv
module tb_link_duplex_resolver;
  localparam int TXT = 22;
  localparam int FDX = 9;

  logic        clk, rst_n, start, duplex_lock, mdio_rd_req, mdio_rd_done;
  logic [4:0]  phy_addr, mdio_phy, mdio_reg;
  logic [15:0] local_adv, mdio_rd_data;
  logic [31:0] mode_in, mode_out;
  logic        busy, done, changed;
  logic [1:0]  result;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  link_duplex_resolver dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
    .local_adv(local_adv), .duplex_lock(duplex_lock), .mode_in(mode_in),
    .mdio_rd_req(mdio_rd_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_rd_done(mdio_rd_done), .mdio_rd_data(mdio_rd_data),
    .busy(busy), .done(done), .result(result), .mode_out(mode_out),
    .changed(changed)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serve one read: wait for request, check target, answer after lat cycles
  task automatic serve(input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] data, input int lat, input bit poke);
    int w = 0;
    while (!mdio_rd_req && w < 30) begin
      chk(done == 0, "R9 done early", done, 0);
      @(negedge clk); w++;
    end
    chk(mdio_rd_req == 1, "R2 request seen", mdio_rd_req, 1);
    chk(mdio_reg == rg, "R2 register", mdio_reg, rg);
    chk(mdio_phy == phy, "R2/R10 phy", mdio_phy, phy);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mdio_rd_req == 0, "R2 one request per read", mdio_rd_req, 0);
      chk(busy == 1, "R9 busy", busy, 1);
      if (poke && i == 0) begin start = 1; phy_addr = phy ^ 5'h1f; end
      else start = 0;
    end
    start = 0;
    mdio_rd_done = 1; mdio_rd_data = data;
    @(negedge clk);
    mdio_rd_done = 0; mdio_rd_data = 16'h0;
  endtask

  task automatic run_case(input string nm, input logic [4:0] phy, input logic [15:0] adv,
                          input bit lock, input logic [31:0] mode,
                          input logic [15:0] st1, input logic [15:0] lpa,
                          input logic [15:0] st2, input int lat, input bit poke);
    logic [15:0] neg;
    logic [31:0] emode;
    logic [1:0]  eres;
    bit          third;
    bit          fast, full;
    third = (st1 != 16'hffff) && !st1[2];
    neg   = lpa & adv;
    fast  = (neg[9:7] != 0);
    full  = lock || neg[8] || (neg[6] && !neg[7]);
    emode = mode;
    if (st1 == 16'hffff) eres = 2'b10;
    else if (third && !st2[2]) eres = 2'b11;
    else begin
      emode[TXT] = !fast;
      emode[FDX] = full;
      eres = (emode != mode) ? 2'b01 : 2'b00;
      if (eres == 2'b00) emode = mode;
    end
    if (eres[1]) emode = mode;

    phy_addr = phy; local_adv = adv; duplex_lock = lock; mode_in = mode;
    start = 1;
    @(negedge clk);
    start = 0;
    phy_addr = 5'h0; local_adv = 16'h0; mode_in = 32'h0; duplex_lock = 0;
    serve(phy, 5'd1, st1, lat, poke);
    serve(phy, 5'd5, lpa, lat + 1, 0);
    if (third) serve(phy, 5'd1, st2, lat + 2, 0);
    chk(done == 0 && mdio_rd_req == 0, {"R9/R2 ", nm, " gap"}, {done, mdio_rd_req}, 0);
    @(negedge clk);
    chk(done == 1, {"R9 ", nm, " done timing"}, done, 1);
    chk(busy == 0, {"R9 ", nm, " busy at done"}, busy, 0);
    chk(result == eres, {"R3/R4/R8 ", nm, " result"}, result, eres);
    chk(mode_out == emode, {"R6/R7/R8 ", nm, " mode"}, mode_out, emode);
    chk(changed == (eres == 2'b01), {"R8 ", nm, " changed"}, changed, eres == 2'b01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done == 0 && busy == 0 && mdio_rd_req == 0, {"R9/R10 ", nm, " idle after"},
          {done, busy, mdio_rd_req}, 0);
    end
    chk(mode_out == emode, {"R8 ", nm, " mode held"}, mode_out, emode);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; phy_addr = 0; local_adv = 0; duplex_lock = 0;
    mode_in = 0; mdio_rd_done = 0; mdio_rd_data = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && changed == 0 && mdio_rd_req == 0, "R1 controls",
        {busy, done, changed, mdio_rd_req}, 0);
    chk(result == 0 && mode_out == 0, "R1 data", {result, mode_out}, 0);
    rst_n = 1;
    @(negedge clk);
    // R6 R7 R8: 100 FD shared, threshold set / duplex clear -> changed
    run_case("fd100", 5'd3, 16'h01e1, 0, 32'h0040_0000, 16'h786d, 16'h45e1, 16'h0, 1, 0);
    // R8: word already resolved -> unchanged
    run_case("same", 5'd3, 16'h01e1, 0, 32'h0000_0200, 16'h786d, 16'h45e1, 16'h0, 2, 0);
    // R3: missing PHY
    run_case("missing", 5'd7, 16'h01e1, 0, 32'h1234_5678, 16'hffff, 16'hffff, 16'h0, 3, 0);
    // R4: link down twice
    run_case("nolink", 5'd9, 16'h01e1, 0, 32'h0000_0000, 16'h7869, 16'h41e1, 16'h7869, 1, 0);
    // R5: latched low, then up on re-read
    run_case("relink", 5'd9, 16'h01e1, 0, 32'h0040_0200, 16'h7869, 16'h4081, 16'h786d, 2, 0);
    // R6: 10 half only -> threshold set, half duplex
    run_case("hd10", 5'd1, 16'h01e1, 0, 32'h0000_0200, 16'h786d, 16'h0021, 16'h0, 1, 0);
    // R7: 100 half with 10 full -> half duplex, threshold clear
    run_case("hd100", 5'd2, 16'h00e1, 0, 32'h0040_0200, 16'h786d, 16'h00c1, 16'h0, 4, 0);
    // R7: 10 full alone -> full, threshold set
    run_case("fd10", 5'd4, 16'h01e1, 0, 32'h8000_0001, 16'h786d, 16'h0041, 16'h0, 1, 0);
    // R7: duplex lock forces full
    run_case("lock", 5'd5, 16'h01e1, 1, 32'h0000_0000, 16'h786d, 16'h0021, 16'h0, 2, 0);
    // R6 R7: advertisement masks partner 100 abilities
    run_case("mask", 5'd6, 16'h0061, 0, 32'h0000_0000, 16'h786d, 16'h01e1, 16'h0, 3, 0);
    // R10: start during a pass is ignored
    run_case("poke", 5'd12, 16'h01e1, 0, 32'h0040_0000, 16'h786d, 16'h0181, 16'h0, 4, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule